// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block works out the divider settings for a fractional-free PLL. It takes a requested output frequency and a reference frequency, both in kHz. It returns the input divider M, the feedback multiplier N and a post-divider index PL. The search walks a bounded, nested candidate space: post-divider indices on the outside, input dividers in the middle and one or two feedback values on the inside. It keeps the candidate whose rounded output lies closest to the target, and it stops at once when the error reaches zero.

A controller pulses `start` with both frequencies on the inputs. It waits while `busy` is high and captures the result in the cycle where `done` pulses. Every quotient the search needs comes from one shared multi-cycle restoring divider, so the search time depends on the data, not on a fixed count. The results stay registered until the next search finishes. A flag marks an exact hit, and a second flag marks a search that found no legal candidate.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, `busy`, `done`, `exact` and `no_valid` are low, and the results read M = 255, N = 8 and PL index 1.
- R2: A `start` seen while idle raises `busy` in the next cycle. `done` is high for exactly one cycle per search, and `busy` is low in that cycle.
- R3: PL indices 0 to 14 select the divide values 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32. `pl_out` reports the index, not the divide value.
- R4: The target T is twice the request. The provisional VCO target is P = T + floor(T/50). The upper VCO limit is 2,064,000 kHz, raised to P when P is larger. The high divide bound is ceil(limit/P) and the low bound is floor(1,000,000/P), both clamped to 1..32. Each bound becomes the first index in 0..13 whose divide value is at least the bound, or index 14 when none qualifies. Only indices from the low one to the high one are searched.
- R5: For each index, M runs upward from 1 to 255. The M sweep ends when floor(ref/M) drops below 12,000, and an M with floor(ref/M) above 38,000 is skipped.
- R6: With V = T times the divide value, the N candidates run from floor(V·M/ref) to ceil(V·M/ref). The M sweep for the current index ends when the floor exceeds 255. Candidates below 8 are skipped, and candidates above 255 end the candidate list.
- R7: A candidate counts only if floor(ref·N/M) lies between 1,000,000 kHz and the upper limit, both inclusive. Its output is floor((VCO + floor(div/2))/div), and its error is the absolute difference from T. The kept result changes only on a strictly smaller error, so the earliest of equal candidates wins.
- R8: The search ends at the first zero-error candidate and sets `exact`.
- R9: When no candidate qualifies, the result is M = 255, N = 8, PL index 1, with `no_valid` high and `exact` low.
- R10: A `start` while busy is ignored. The results and flags change only in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search using the present frequency inputs |
| req_khz | input | FREQ_W | Requested output frequency in kHz |
| ref_khz | input | FREQ_W | Reference frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results update |
| m_out | output | M_W | Chosen input divider |
| n_out | output | N_W | Chosen feedback multiplier |
| pl_out | output | 4 | Chosen post-divider index |
| exact | output | 1 | Chosen candidate has zero error |
| no_valid | output | 1 | No candidate satisfied the limits |

## Verification
`busy` must rise one cycle after an accepted `start`. The result fields, `exact` and `no_valid` all change in the single cycle where `done` is high. The number of cycles up to that point depends on how many dividers and candidates the data lets through. For that reason the bench does not predict a fixed latency. It drives and samples on falling edges, checks `busy` one cycle after `start`, waits for `done` and compares every result in that cycle. It then checks in the following cycle that `done` has dropped. Between searches the outputs are sampled again after unrelated input changes, to show they held.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

   localparam int PL_IDX_W      = 4;
   localparam int PL_LAST       = 14;
   localparam int PL_SEARCH_TOP = 13;
   localparam int PDIV_W        = 6;

   typedef logic [PL_IDX_W-1:0] pl_idx_t;
   typedef logic [PDIV_W-1:0]   pdiv_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_MARGIN,
      ST_HI_BND,
      ST_LO_BND,
      ST_MAP,
      ST_PL_SETUP,
      ST_REF_DIV,
      ST_N_DIV,
      ST_N_CHECK,
      ST_VCO_DIV,
      ST_OUT_DIV,
      ST_NEXT_M,
      ST_NEXT_PL,
      ST_FINISH
   } srch_state_t;

   // post-divider index to divide value; deliberately non-monotonic above index 9
   function automatic pdiv_t pdiv_of(pl_idx_t idx);
      pdiv_t v;
      case (idx)
         4'd0:    v = 6'd1;
         4'd1:    v = 6'd2;
         4'd2:    v = 6'd3;
         4'd3:    v = 6'd4;
         4'd4:    v = 6'd5;
         4'd5:    v = 6'd6;
         4'd6:    v = 6'd8;
         4'd7:    v = 6'd10;
         4'd8:    v = 6'd12;
         4'd9:    v = 6'd16;
         4'd10:   v = 6'd12;
         4'd11:   v = 6'd16;
         4'd12:   v = 6'd20;
         4'd13:   v = 6'd24;
         4'd14:   v = 6'd32;
         default: v = 6'd1;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/pllsrch_divider.sv
module pllsrch_divider #(
   parameter int W = 40
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         busy,
   output logic         fin,
   output logic [W-1:0] quot,
   output logic [W-1:0] rem
);

   localparam int CNT_W = $clog2(W + 1);

   if (W < 2) begin : g_bad_width
      $error("pllsrch_divider: W must be at least 2");
   end

   logic [W-1:0]     dsr_r, quo_r, rem_r, dvd_r;
   logic [CNT_W-1:0] cnt_r;
   logic             run_r, fin_r;
   logic [W:0]       part, diff;
   logic             ge;

   assign part = {rem_r, quo_r[W-1]};
   assign diff = part - {1'b0, dsr_r};
   assign ge   = (part >= {1'b0, dsr_r});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dsr_r <= '0;
         quo_r <= '0;
         rem_r <= '0;
         dvd_r <= '0;
         cnt_r <= '0;
         run_r <= 1'b0;
         fin_r <= 1'b0;
      end else begin
         fin_r <= 1'b0;
         if (start && !run_r) begin
            dsr_r <= divisor;
            quo_r <= dividend;
            dvd_r <= dividend;
            rem_r <= '0;
            cnt_r <= CNT_W'(W);
            run_r <= 1'b1;
         end else if (run_r) begin
            quo_r <= {quo_r[W-2:0], ge};
            rem_r <= ge ? diff[W-1:0] : part[W-1:0];
            cnt_r <= cnt_r - 1'b1;
            if (cnt_r == CNT_W'(1)) begin
               run_r <= 1'b0;
               fin_r <= 1'b1;
            end
         end
      end
   end

   assign busy = run_r;
   assign fin  = fin_r;
   assign quot = quo_r;
   assign rem  = rem_r;

   AST_DIV_REMAINDER: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_r && dsr_r != '0) |-> (rem_r < dsr_r)); // R7

   AST_DIV_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_r && dsr_r != '0) |->
         (({{W{1'b0}}, quo_r} * {{W{1'b0}}, dsr_r}) + {{W{1'b0}}, rem_r}
            == {{W{1'b0}}, dvd_r})); // R7

endmodule

// File: rtl/pllsrch_pdiv_lut.sv
module pllsrch_pdiv_lut
   import pllsrch_pkg::*;
(
   input  pl_idx_t idx,
   output pdiv_t   div_val
);

   assign div_val = pdiv_of(idx);

endmodule

// File: rtl/pllsrch_bound_map.sv
module pllsrch_bound_map
   import pllsrch_pkg::*;
(
   input  pdiv_t   bound,
   output pl_idx_t idx
);

   logic [PL_SEARCH_TOP:0] hit;

   for (genvar i = 0; i <= PL_SEARCH_TOP; i++) begin : g_hit
      assign hit[i] = (pdiv_of(pl_idx_t'(i)) >= bound);
   end

   // lowest qualifying index wins; fall back to the last table entry
   always_comb begin
      idx = pl_idx_t'(PL_LAST);
      for (int i = PL_SEARCH_TOP; i >= 0; i--) begin
         if (hit[i]) idx = pl_idx_t'(i);
      end
   end

endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
   import pllsrch_pkg::*;
#(
   parameter int FREQ_W       = 24,
   parameter int DIV_W        = 40,
   parameter int VCO_MIN_KHZ  = 1_000_000,
   parameter int VCO_MAX_KHZ  = 2_064_000,
   parameter int UREF_MIN_KHZ = 12_000,
   parameter int UREF_MAX_KHZ = 38_000,
   parameter int M_LO         = 1,
   parameter int M_HI         = 255,
   parameter int N_LO         = 8,
   parameter int N_HI         = 255,
   parameter int PDIV_LO      = 1,
   parameter int PDIV_HI      = 32,
   parameter int MARGIN_DEN   = 50,
   parameter int PL_DEFAULT   = 1,
   localparam int M_W         = $clog2(M_HI + 1),
   localparam int N_W         = $clog2(N_HI + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] req_khz,
   input  logic [FREQ_W-1:0] ref_khz,
   output logic              busy,
   output logic              done,
   output logic [M_W-1:0]    m_out,
   output logic [N_W-1:0]    n_out,
   output logic [3:0]        pl_out,
   output logic              exact,
   output logic              no_valid
);

   localparam int NC_W = N_W + 1;

   if (DIV_W < FREQ_W + 1 + PDIV_W + M_W) begin : g_bad_divw
      $error("pll_coef_search: DIV_W too narrow for target x divide x M");
   end
   if (DIV_W < FREQ_W + NC_W) begin : g_bad_divw2
      $error("pll_coef_search: DIV_W too narrow for ref x N");
   end
   if (M_LO < 1 || M_LO > M_HI) begin : g_bad_m
      $error("pll_coef_search: M range illegal");
   end
   if (N_LO > N_HI) begin : g_bad_n
      $error("pll_coef_search: N range illegal");
   end
   if (PDIV_LO < 1 || PDIV_HI > 63 || PDIV_LO > PDIV_HI) begin : g_bad_pdiv
      $error("pll_coef_search: post-divide bounds illegal");
   end
   if (MARGIN_DEN < 1) begin : g_bad_margin
      $error("pll_coef_search: margin denominator must be positive");
   end
   if (PL_DEFAULT < 0 || PL_DEFAULT > PL_LAST) begin : g_bad_pldef
      $error("pll_coef_search: default index out of table");
   end

   srch_state_t       state_r;
   logic              wait_r;
   logic [FREQ_W-1:0] ref_r;
   logic [DIV_W-1:0]  tgt_r, pv_r, maxv_r, vt_r, vco_r, best_d_r;
   pdiv_t             lo_b_r, hi_b_r;
   pl_idx_t           pl_r, pl_hi_r, best_pl_r;
   logic [M_W-1:0]    m_r, best_m_r;
   logic [NC_W-1:0]   n_r, n2_r;
   logic [N_W-1:0]    best_n_r;
   logic              done_r, exact_r, none_r;
   logic [M_W-1:0]    m_o_r;
   logic [N_W-1:0]    n_o_r;
   pl_idx_t           pl_o_r;

   logic [DIV_W-1:0]  div_dvd, div_dsr, div_q, div_rem;
   logic              div_go, div_busy, div_fin, div_state;
   pdiv_t             cur_div;
   pl_idx_t           lo_idx, hi_idx;
   logic [DIV_W-1:0]  pv_next, delta;

   pllsrch_divider #(.W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_go),
      .dividend (div_dvd),
      .divisor  (div_dsr),
      .busy     (div_busy),
      .fin      (div_fin),
      .quot     (div_q),
      .rem      (div_rem)
   );

   pllsrch_pdiv_lut u_lut (
      .idx     (pl_r),
      .div_val (cur_div)
   );

   pllsrch_bound_map u_map_lo (
      .bound (lo_b_r),
      .idx   (lo_idx)
   );

   pllsrch_bound_map u_map_hi (
      .bound (hi_b_r),
      .idx   (hi_idx)
   );

   function automatic pdiv_t clamp_bound(logic [DIV_W-1:0] q);
      if (q < DIV_W'(PDIV_LO)) return pdiv_t'(PDIV_LO);
      if (q > DIV_W'(PDIV_HI)) return pdiv_t'(PDIV_HI);
      return q[PDIV_W-1:0];
   endfunction

   always_comb begin
      div_state = 1'b0;
      div_dvd   = '0;
      div_dsr   = DIV_W'(1);
      case (state_r)
         ST_MARGIN: begin
            div_state = 1'b1;
            div_dvd   = tgt_r;
            div_dsr   = DIV_W'(MARGIN_DEN);
         end
         ST_HI_BND: begin
            div_state = 1'b1;
            div_dvd   = maxv_r + pv_r - DIV_W'(1);
            div_dsr   = pv_r;
         end
         ST_LO_BND: begin
            div_state = 1'b1;
            div_dvd   = DIV_W'(VCO_MIN_KHZ);
            div_dsr   = pv_r;
         end
         ST_REF_DIV: begin
            div_state = 1'b1;
            div_dvd   = DIV_W'(ref_r);
            div_dsr   = DIV_W'(m_r);
         end
         ST_N_DIV: begin
            div_state = 1'b1;
            div_dvd   = vt_r * DIV_W'(m_r);
            div_dsr   = DIV_W'(ref_r);
         end
         ST_VCO_DIV: begin
            div_state = 1'b1;
            div_dvd   = DIV_W'(ref_r) * DIV_W'(n_r);
            div_dsr   = DIV_W'(m_r);
         end
         ST_OUT_DIV: begin
            div_state = 1'b1;
            div_dvd   = vco_r + DIV_W'(cur_div >> 1);
            div_dsr   = DIV_W'(cur_div);
         end
         default: ;
      endcase
   end

   assign div_go  = div_state && !wait_r;
   assign pv_next = tgt_r + div_q;
   assign delta   = (div_q >= tgt_r) ? (div_q - tgt_r) : (tgt_r - div_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_r   <= ST_IDLE;
         wait_r    <= 1'b0;
         ref_r     <= '0;
         tgt_r     <= '0;
         pv_r      <= '0;
         maxv_r    <= '0;
         vt_r      <= '0;
         vco_r     <= '0;
         best_d_r  <= '1;
         lo_b_r    <= pdiv_t'(PDIV_LO);
         hi_b_r    <= pdiv_t'(PDIV_LO);
         pl_r      <= '0;
         pl_hi_r   <= '0;
         m_r       <= M_W'(M_LO);
         n_r       <= '0;
         n2_r      <= '0;
         best_m_r  <= M_W'(M_HI);
         best_n_r  <= N_W'(N_LO);
         best_pl_r <= pl_idx_t'(PL_DEFAULT);
         done_r    <= 1'b0;
         exact_r   <= 1'b0;
         none_r    <= 1'b0;
         m_o_r     <= M_W'(M_HI);
         n_o_r     <= N_W'(N_LO);
         pl_o_r    <= pl_idx_t'(PL_DEFAULT);
      end else begin
         done_r <= 1'b0;
         if (div_go) wait_r <= 1'b1;
         case (state_r)
            ST_IDLE: begin
               if (start) begin
                  ref_r     <= ref_khz;
                  tgt_r     <= DIV_W'(req_khz) << 1;
                  best_d_r  <= '1;
                  best_m_r  <= M_W'(M_HI);
                  best_n_r  <= N_W'(N_LO);
                  best_pl_r <= pl_idx_t'(PL_DEFAULT);
                  state_r   <= ST_MARGIN;
               end
            end
            ST_MARGIN: begin
               if (div_fin) begin
                  wait_r  <= 1'b0;
                  pv_r    <= pv_next;
                  maxv_r  <= (pv_next > DIV_W'(VCO_MAX_KHZ)) ? pv_next : DIV_W'(VCO_MAX_KHZ);
                  state_r <= ST_HI_BND;
               end
            end
            ST_HI_BND: begin
               if (div_fin) begin
                  wait_r  <= 1'b0;
                  hi_b_r  <= clamp_bound(div_q);
                  state_r <= ST_LO_BND;
               end
            end
            ST_LO_BND: begin
               if (div_fin) begin
                  wait_r  <= 1'b0;
                  lo_b_r  <= clamp_bound(div_q);
                  state_r <= ST_MAP;
               end
            end
            ST_MAP: begin
               pl_r    <= lo_idx;
               pl_hi_r <= hi_idx;
               state_r <= (lo_idx > hi_idx) ? ST_FINISH : ST_PL_SETUP;
            end
            ST_PL_SETUP: begin
               vt_r    <= tgt_r * DIV_W'(cur_div);
               m_r     <= M_W'(M_LO);
               state_r <= ST_REF_DIV;
            end
            ST_REF_DIV: begin
               if (div_fin) begin
                  wait_r <= 1'b0;
                  if (div_q < DIV_W'(UREF_MIN_KHZ))      state_r <= ST_NEXT_PL;
                  else if (div_q > DIV_W'(UREF_MAX_KHZ)) state_r <= ST_NEXT_M;
                  else                                   state_r <= ST_N_DIV;
               end
            end
            ST_N_DIV: begin
               if (div_fin) begin
                  wait_r <= 1'b0;
                  if (div_q > DIV_W'(N_HI)) begin
                     state_r <= ST_NEXT_PL;
                  end else begin
                     n_r     <= div_q[NC_W-1:0];
                     n2_r    <= div_q[NC_W-1:0] + NC_W'(div_rem != '0);
                     state_r <= ST_N_CHECK;
                  end
               end
            end
            ST_N_CHECK: begin
               if (n_r > n2_r)                state_r <= ST_NEXT_M;
               else if (n_r < NC_W'(N_LO))    n_r     <= n_r + 1'b1;
               else if (n_r > NC_W'(N_HI))    state_r <= ST_NEXT_M;
               else                           state_r <= ST_VCO_DIV;
            end
            ST_VCO_DIV: begin
               if (div_fin) begin
                  wait_r <= 1'b0;
                  if (div_q >= DIV_W'(VCO_MIN_KHZ) && div_q <= maxv_r) begin
                     vco_r   <= div_q;
                     state_r <= ST_OUT_DIV;
                  end else begin
                     n_r     <= n_r + 1'b1;
                     state_r <= ST_N_CHECK;
                  end
               end
            end
            ST_OUT_DIV: begin
               if (div_fin) begin
                  wait_r <= 1'b0;
                  if (delta < best_d_r) begin
                     best_d_r  <= delta;
                     best_m_r  <= m_r;
                     best_n_r  <= n_r[N_W-1:0];
                     best_pl_r <= pl_r;
                  end
                  if (delta == '0) begin
                     state_r <= ST_FINISH;
                  end else begin
                     n_r     <= n_r + 1'b1;
                     state_r <= ST_N_CHECK;
                  end
               end
            end
            ST_NEXT_M: begin
               if (m_r == M_W'(M_HI)) begin
                  state_r <= ST_NEXT_PL;
               end else begin
                  m_r     <= m_r + 1'b1;
                  state_r <= ST_REF_DIV;
               end
            end
            ST_NEXT_PL: begin
               if (pl_r >= pl_hi_r) begin
                  state_r <= ST_FINISH;
               end else begin
                  pl_r    <= pl_r + 1'b1;
                  state_r <= ST_PL_SETUP;
               end
            end
            ST_FINISH: begin
               m_o_r   <= best_m_r;
               n_o_r   <= best_n_r;
               pl_o_r  <= best_pl_r;
               exact_r <= (best_d_r == '0);
               none_r  <= (best_d_r == '1);
               done_r  <= 1'b1;
               state_r <= ST_IDLE;
            end
            default: state_r <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_r != ST_IDLE);
   assign done     = done_r;
   assign m_out    = m_o_r;
   assign n_out    = n_o_r;
   assign pl_out   = pl_o_r;
   assign exact    = exact_r;
   assign no_valid = none_r;

   AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy); // R2

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R2

   AST_PL_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      pl_out <= 4'(PL_LAST)); // R3

   AST_DIV_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
      div_go |-> !div_busy); // R7

   AST_CANDIDATE_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !no_valid) |-> (m_out >= M_W'(M_LO) && n_out >= N_W'(N_LO))); // R6

   AST_EXACT_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      exact |-> !no_valid); // R8

   AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({m_out, n_out, pl_out, exact, no_valid})); // R10

endmodule

// File: tb/tb_pll_coef_search.sv
module tb_pll_coef_search;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;
   localparam longint ALL1   = (64'd1 << 40) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] req_khz = '0;
   logic [23:0] ref_khz = '0;
   logic        busy, done, exact, no_valid;
   logic [7:0]  m_out, n_out;
   logic [3:0]  pl_out;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pll_coef_search dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .req_khz  (req_khz),
      .ref_khz  (ref_khz),
      .busy     (busy),
      .done     (done),
      .m_out    (m_out),
      .n_out    (n_out),
      .pl_out   (pl_out),
      .exact    (exact),
      .no_valid (no_valid)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic longint tb_div(input int i);
      case (i)
         0: return 1;   1: return 2;   2: return 3;   3: return 4;
         4: return 5;   5: return 6;   6: return 8;   7: return 10;
         8: return 12;  9: return 16;  10: return 12; 11: return 16;
         12: return 20; 13: return 24; default: return 32;
      endcase
   endfunction

   function automatic int tb_first(input longint b);
      for (int i = 0; i < 14; i++) if (tb_div(i) >= b) return i;
      return 14;
   endfunction

   task automatic model(input longint rq, input longint rf,
                        output longint em, output longint en, output longint ep,
                        output bit ex, output bit nv);
      longint tgt, pv, vmax, hb, lb, best;
      int li, hi;
      bit stop;
      tgt = 2 * rq;
      pv = tgt + tgt / 50;
      vmax = (pv > 2064000) ? pv : 2064000;
      hb = (vmax + pv - 1) / pv;
      if (hb < 1) hb = 1;
      if (hb > 32) hb = 32;
      lb = 1000000 / pv;
      if (lb < 1) lb = 1;
      if (lb > 32) lb = 32;
      li = tb_first(lb);
      hi = tb_first(hb);
      best = ALL1; em = 255; en = 8; ep = 1; stop = 1'b0;
      for (int p = li; p <= hi && !stop; p++) begin
         longint d, vt;
         d = tb_div(p);
         vt = tgt * d;
         for (longint m = 1; m <= 255 && !stop; m++) begin
            longint u, q, n2;
            u = rf / m;
            if (u < 12000) break;
            if (u > 38000) continue;
            q = vt * m / rf;
            n2 = q + (((vt * m) % rf) != 0 ? 1 : 0);
            if (q > 255) break;
            for (longint n = q; n <= n2 && !stop; n++) begin
               longint vco, lwv, dl;
               if (n < 8) continue;
               if (n > 255) break;
               vco = rf * n / m;
               if (vco >= 1000000 && vco <= vmax) begin
                  lwv = (vco + d / 2) / d;
                  dl = (lwv > tgt) ? lwv - tgt : tgt - lwv;
                  if (dl < best) begin
                     best = dl; em = m; en = n; ep = p;
                     if (dl == 0) stop = 1'b1;
                  end
               end
            end
         end
      end
      ex = (best == 0);
      nv = (best == ALL1);
   endtask

   // launch one search; optionally pulse start again mid-run with another request
   task automatic launch(input longint rq, input longint rf, input bit poke);
      @(negedge clk);
      req_khz = 24'(rq);
      ref_khz = 24'(rf);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R2", "busy one cycle after start", longint'(busy), 1);
      if (poke) begin
         repeat (4) @(negedge clk);
         req_khz = 24'd600000;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      check(busy == 1'b0, "R2", "busy low while done", longint'(busy), 0);
   endtask

   task automatic after_done();
      @(negedge clk);
      check(done == 1'b0, "R2", "done lasts one cycle", longint'(done), 0);
   endtask

   task automatic run_model(input longint rq, input longint rf, input string tag);
      longint em, en, ep;
      bit ex, nv;
      model(rq, rf, em, en, ep, ex, nv);
      launch(rq, rf, 1'b0);
      check(longint'(m_out) == em, tag, "M", longint'(m_out), em);
      check(longint'(n_out) == en, tag, "N", longint'(n_out), en);
      check(longint'(pl_out) == ep, tag, "PL index", longint'(pl_out), ep);
      check(exact == ex, tag, "exact flag", longint'(exact), longint'(ex));
      check(no_valid == nv, tag, "no_valid flag", longint'(no_valid), longint'(nv));
      after_done();
   endtask

   task automatic run_fixed(input longint rq, input longint rf, input string tag,
                            input longint em, input longint en, input longint ep,
                            input bit ex, input bit nv);
      launch(rq, rf, 1'b0);
      check(longint'(m_out) == em, tag, "M", longint'(m_out), em);
      check(longint'(n_out) == en, tag, "N", longint'(n_out), en);
      check(longint'(pl_out) == ep, tag, "PL index", longint'(pl_out), ep);
      check(exact == ex, tag, "exact flag", longint'(exact), longint'(ex));
      check(no_valid == nv, tag, "no_valid flag", longint'(no_valid), longint'(nv));
      after_done();
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      longint refs_a [4] = '{12000, 19200, 26000, 38400};
      longint reqs_a [5] = '{72000, 180000, 396000, 612000, 852000};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(busy == 1'b0, "R1", "busy", longint'(busy), 0);
      check(done == 1'b0, "R1", "done", longint'(done), 0);
      check(m_out == 8'd255, "R1", "M", longint'(m_out), 255);
      check(n_out == 8'd8, "R1", "N", longint'(n_out), 8);
      check(pl_out == 4'd1, "R1", "PL index", longint'(pl_out), 1);
      check(exact == 1'b0, "R1", "exact", longint'(exact), 0);
      check(no_valid == 1'b0, "R1", "no_valid", longint'(no_valid), 0);

      // R8 hand-worked exact hit: divide 8 at index 6
      run_fixed(72000, 12000, "R8", 1, 96, 6, 1'b1, 1'b0);
      // R4 raised VCO ceiling lets 2.4 GHz through at index 0
      run_fixed(1200000, 12000, "R4", 1, 200, 0, 1'b1, 1'b0);
      // R4 both bounds past 24 fall back to index 14
      run_fixed(19000, 38400, "R4", 3, 95, 14, 1'b1, 1'b0);
      // R9 reference too slow for any M
      run_fixed(300000, 5000, "R9", 255, 8, 1, 1'b0, 1'b1);
      // R6 every N candidate below the minimum
      run_fixed(1000, 12000, "R6", 255, 8, 1, 1'b0, 1'b1);

      // R10 start while busy is ignored, then results hold
      launch(72000, 12000, 1'b1);
      check(m_out == 8'd1 && n_out == 8'd96 && pl_out == 4'd6, "R10", "result of first request",
            longint'({m_out, n_out, pl_out}), longint'({8'd1, 8'd96, 4'd6}));
      after_done();
      req_khz = 24'd852000;
      ref_khz = 24'd38400;
      repeat (20) @(negedge clk);
      check(m_out == 8'd1 && n_out == 8'd96 && pl_out == 4'd6 && exact == 1'b1, "R10",
            "results hold without start", longint'({m_out, n_out, pl_out}),
            longint'({8'd1, 8'd96, 4'd6}));

      // R7 sweep of operating points against the arithmetic model
      foreach (refs_a[i]) begin
         foreach (reqs_a[j]) run_model(reqs_a[j], refs_a[i], "R7");
      end
      // R3 wide index range crossing the non-monotonic table entries
      run_model(60000, 12000, "R3");
      run_model(60000, 38400, "R3");
      run_model(57000, 26000, "R3");
      // R5 references that skip the first M values
      run_model(300000, 50000, "R5");
      run_model(450000, 76000, "R5");
      run_model(333333, 38400, "R5");

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule